// File: doc/BRIEF.md
# SPI Host Offload Register Front End

This block is the memory-mapped face of a command-driven SPI host. Software writes 16-bit commands and outgoing data words into two queues and reads incoming data words back from a third. A separate command executor, which is outside this block, drains the command and outgoing queues and fills the incoming queue through valid/ready handshakes. When the executor finishes a synchronisation command it pulses a sync strobe carrying an 8-bit identifier. The block records that identifier and raises a sticky interrupt flag for it.

Three more interrupt conditions follow the queue fill levels: command queue almost empty, outgoing queue almost empty and incoming queue almost full. Each condition can be enabled on its own. A single level-sensitive interrupt line is high while any enabled condition is present. A reset register holds the executor and all three queues in reset until software releases it.

The register bus is a simple single-cycle strobe interface. A write takes effect on the clock edge where the write strobe is sampled. Read data is registered and appears the cycle after the read strobe.

Top module: `spi_offload_regs`

## Requirements
- R1: After hardware reset, the reset register (0x40) reads 1 and `engineReset` is high. The enable register (0x80) and the sync identifier (0xC0) read 0. Both room counters (0xD0, 0xD4) read their queue depth, the incoming level (0xD8) reads 0, and `irq` is low.
- R2: Writing 1 to bit 0 of 0x40 drives `engineReset` high and empties all three queues. While the bit is held at 1, pushes are dropped and `rxReady` is low. Writing 0 releases the reset.
- R3: A write to 0xE0 pushes the low 16 bits of the write data into the command queue. Commands leave on `cmdData` in first-in-first-out order, one per cycle in which `cmdValid` and `cmdReady` are both high. Reading 0xD0 returns depth minus fill.
- R4: A write to 0xE4 pushes a 32-bit word into the outgoing queue. Words leave on `txData` in order under the `txValid`/`txReady` handshake. Reading 0xD4 returns depth minus fill.
- R5: The executor pushes into the incoming queue when `rxValid` and `rxReady` are both high. Reading 0xD8 returns the fill level. Reading 0xE8 returns the oldest word and removes it. Reading 0xEC returns the oldest word and leaves the queue unchanged.
- R6: A push into a full queue is dropped and leaves its contents and level unchanged. `rxReady` is low while the incoming queue is full. A read of 0xE8 or 0xEC on an empty queue returns 0 and changes nothing.
- R7: Pending register 0x84 bits 0, 1 and 2 follow the queue levels, with no memory. Bit 0 is set while the command fill is at most `CMD_AE_LEVEL`. Bit 1 is set while the outgoing fill is at most `TX_AE_LEVEL`. Bit 2 is set while the incoming fill is at least `RX_AF_LEVEL`.
- R8: A cycle with `syncValid` high stores `syncId` into 0xC0 and sets pending bit 3. Bit 3 stays set until it is cleared.
- R9: Writing 0x84 with bit 3 set clears pending bit 3. Writing 0 to bit 3 leaves it alone, and writes have no effect on bits 0 to 2. If a sync strobe arrives in the same cycle as the clearing write, the bit stays set.
- R10: Register 0x80 holds a 4-bit enable mask, one bit per pending bit. Register 0x88 reads pending AND enable. `irq` is high exactly when that value is nonzero.
- R11: Read data appears on `busRdData` one cycle after `busRdEn`. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 8 | Register byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| engineReset | output | 1 | Holds the executor in reset |
| cmdValid | output | 1 | Command queue not empty |
| cmdReady | input | 1 | Executor takes a command |
| cmdData | output | 16 | Oldest command |
| txValid | output | 1 | Outgoing queue not empty |
| txReady | input | 1 | Executor takes a data word |
| txData | output | 32 | Oldest outgoing word |
| rxValid | input | 1 | Executor offers an incoming word |
| rxReady | output | 1 | Incoming queue can accept |
| rxData | input | 32 | Incoming word |
| syncValid | input | 1 | Sync completion strobe |
| syncId | input | 8 | Sync identifier |

## Verification
A wrong pointer or count inside a queue shows up at the ports on the next read of the room or level register. It also shows as a reordered, duplicated or missing word on the executor side or at the pop address. Because the almost-empty and almost-full flags are computed from the levels, a miscounted queue also shows as a wrong pending bit and a wrong `irq` in that same cycle. A sticky sync flag that is cleared or set wrongly is visible on the next read of the pending or source register, and on `irq` one cycle after the offending strobe or write.

// File: rtl/soff_pkg.sv
package soff_pkg;

  localparam logic [7:0] ADR_RESET   = 8'h40;
  localparam logic [7:0] ADR_IEN     = 8'h80;
  localparam logic [7:0] ADR_IPEND   = 8'h84;
  localparam logic [7:0] ADR_ISRC    = 8'h88;
  localparam logic [7:0] ADR_SYNC    = 8'hC0;
  localparam logic [7:0] ADR_CMDROOM = 8'hD0;
  localparam logic [7:0] ADR_TXROOM  = 8'hD4;
  localparam logic [7:0] ADR_RXLVL   = 8'hD8;
  localparam logic [7:0] ADR_CMDPUSH = 8'hE0;
  localparam logic [7:0] ADR_TXPUSH  = 8'hE4;
  localparam logic [7:0] ADR_RXPOP   = 8'hE8;
  localparam logic [7:0] ADR_RXPEEK  = 8'hEC;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RESET, SEL_IEN, SEL_IPEND, SEL_ISRC, SEL_SYNC,
    SEL_CMDROOM, SEL_TXROOM, SEL_RXLVL, SEL_RXPOP, SEL_RXPEEK
  } rdsel_e;

  typedef struct packed {
    logic   pushCmd;
    logic   pushTx;
    logic   popRx;
    logic   wrReset;
    logic   wrEnable;
    logic   wrPending;
    logic   rdStrobe;
    rdsel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/soff_fifo.sv
module soff_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty
);

  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
  localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  assign full     = (level == DEPTH_L);
  assign empty    = (level == '0);
  assign doPush   = push && !full && !flush;
  assign doPop    = pop && !empty && !flush;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      level <= level + 1'b1;
      else if (doPop && !doPush) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  // R6
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_L);

  // R6
  push_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (level == $past(level)));

  // R2
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

endmodule

// File: rtl/soff_ctrl.sv
module soff_ctrl
  import soff_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);

  logic [7:0] a;
  assign a = busAddr[7:0];

  always_comb begin
    stb = '0;
    stb.rdStrobe = busRdEn;
    if (busWrEn) begin
      unique case (a)
        ADR_RESET:   stb.wrReset   = 1'b1;
        ADR_IEN:     stb.wrEnable  = 1'b1;
        ADR_IPEND:   stb.wrPending = 1'b1;
        ADR_CMDPUSH: stb.pushCmd   = 1'b1;
        ADR_TXPUSH:  stb.pushTx    = 1'b1;
        default: ;
      endcase
    end
    if (busRdEn) begin
      unique case (a)
        ADR_RESET:   stb.rdSel = SEL_RESET;
        ADR_IEN:     stb.rdSel = SEL_IEN;
        ADR_IPEND:   stb.rdSel = SEL_IPEND;
        ADR_ISRC:    stb.rdSel = SEL_ISRC;
        ADR_SYNC:    stb.rdSel = SEL_SYNC;
        ADR_CMDROOM: stb.rdSel = SEL_CMDROOM;
        ADR_TXROOM:  stb.rdSel = SEL_TXROOM;
        ADR_RXLVL:   stb.rdSel = SEL_RXLVL;
        ADR_RXPOP:   begin stb.rdSel = SEL_RXPOP; stb.popRx = 1'b1; end
        ADR_RXPEEK:  stb.rdSel = SEL_RXPEEK;
        default:     stb.rdSel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/soff_data.sv
module soff_data
  import soff_pkg::*;
#(
  parameter int CMD_DEPTH    = 8,
  parameter int TX_DEPTH     = 8,
  parameter int RX_DEPTH     = 8,
  parameter int CMD_AE_LEVEL = 2,
  parameter int TX_AE_LEVEL  = 2,
  parameter int RX_AF_LEVEL  = 6,
  parameter int CMD_W        = 16,
  parameter int DATA_W       = 32,
  parameter int ID_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq,
  output logic              engineReset,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [CMD_W-1:0]  cmdData,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [DATA_W-1:0] rxData,
  input  logic              syncValid,
  input  logic [ID_W-1:0]   syncId
);

  localparam int CLW = $clog2(CMD_DEPTH + 1);
  localparam int TLW = $clog2(TX_DEPTH + 1);
  localparam int RLW = $clog2(RX_DEPTH + 1);
  localparam logic [CLW-1:0] CMD_AE_L = CLW'(CMD_AE_LEVEL);
  localparam logic [TLW-1:0] TX_AE_L  = TLW'(TX_AE_LEVEL);
  localparam logic [RLW-1:0] RX_AF_L  = RLW'(RX_AF_LEVEL);

  logic              softReset;
  logic [3:0]        ienReg;
  logic              syncPend;
  logic [ID_W-1:0]   syncIdReg;
  logic [3:0]        pending, source;
  logic [CLW-1:0]    cmdLvl;
  logic [TLW-1:0]    txLvl;
  logic [RLW-1:0]    rxLvl;
  logic              cmdFull, cmdEmpty, txFull, txEmpty, rxFull, rxEmpty;
  logic [DATA_W-1:0] rxHead, rxHeadSafe, rdMux;

  assign engineReset = softReset;

  soff_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) cmdQ (
    .clk, .rst_n, .flush(softReset),
    .push(stb.pushCmd), .pushData(busWrData[CMD_W-1:0]),
    .pop(cmdReady), .headData(cmdData),
    .level(cmdLvl), .full(cmdFull), .empty(cmdEmpty));

  soff_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) txQ (
    .clk, .rst_n, .flush(softReset),
    .push(stb.pushTx), .pushData(busWrData),
    .pop(txReady), .headData(txData),
    .level(txLvl), .full(txFull), .empty(txEmpty));

  soff_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) rxQ (
    .clk, .rst_n, .flush(softReset),
    .push(rxValid), .pushData(rxData),
    .pop(stb.popRx), .headData(rxHead),
    .level(rxLvl), .full(rxFull), .empty(rxEmpty));

  assign cmdValid   = !cmdEmpty;
  assign txValid    = !txEmpty;
  assign rxReady    = !rxFull && !softReset;
  assign rxHeadSafe = rxEmpty ? '0 : rxHead;

  assign pending = {syncPend, (rxLvl >= RX_AF_L), (txLvl <= TX_AE_L), (cmdLvl <= CMD_AE_L)};
  assign source  = pending & ienReg;
  assign irq     = |source;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      softReset <= 1'b1;
      ienReg    <= '0;
      syncPend  <= 1'b0;
      syncIdReg <= '0;
    end else begin
      if (stb.wrReset)  softReset <= busWrData[0];
      if (stb.wrEnable) ienReg    <= busWrData[3:0];
      if (syncValid) begin
        syncPend  <= 1'b1;
        syncIdReg <= syncId;
      end else if (stb.wrPending && busWrData[3]) begin
        syncPend <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_RESET:   rdMux = DATA_W'(softReset);
      SEL_IEN:     rdMux = DATA_W'(ienReg);
      SEL_IPEND:   rdMux = DATA_W'(pending);
      SEL_ISRC:    rdMux = DATA_W'(source);
      SEL_SYNC:    rdMux = DATA_W'(syncIdReg);
      SEL_CMDROOM: rdMux = DATA_W'(CMD_DEPTH) - DATA_W'(cmdLvl);
      SEL_TXROOM:  rdMux = DATA_W'(TX_DEPTH) - DATA_W'(txLvl);
      SEL_RXLVL:   rdMux = DATA_W'(rxLvl);
      SEL_RXPOP,
      SEL_RXPEEK:  rdMux = rxHeadSafe;
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            busRdData <= '0;
    else if (stb.rdStrobe) busRdData <= rdMux;
  end

  // R8
  sync_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syncValid |=> (syncPend && syncIdReg == $past(syncId)));

  // R9
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrPending && busWrData[3] && !syncValid) |=> !syncPend);

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ienReg == 4'b0000) |-> !irq);

  // R2
  reset_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    softReset |-> !rxReady);

endmodule

// File: rtl/spi_offload_regs.sv
module spi_offload_regs
  import soff_pkg::*;
#(
  parameter int CMD_DEPTH    = 8,
  parameter int TX_DEPTH     = 8,
  parameter int RX_DEPTH     = 8,
  parameter int CMD_AE_LEVEL = 2,
  parameter int TX_AE_LEVEL  = 2,
  parameter int RX_AF_LEVEL  = 6,
  parameter int ADDR_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              irq,
  output logic              engineReset,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [15:0]       cmdData,
  output logic              txValid,
  input  logic              txReady,
  output logic [31:0]       txData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [31:0]       rxData,
  input  logic              syncValid,
  input  logic [7:0]        syncId
);

  strobe_t stb;

  soff_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busWrEn, .busRdEn, .busAddr, .stb);

  soff_data #(
    .CMD_DEPTH(CMD_DEPTH), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH),
    .CMD_AE_LEVEL(CMD_AE_LEVEL), .TX_AE_LEVEL(TX_AE_LEVEL), .RX_AF_LEVEL(RX_AF_LEVEL),
    .CMD_W(16), .DATA_W(32), .ID_W(8)
  ) data_i (
    .clk, .rst_n, .stb, .busWrData, .busRdData, .irq, .engineReset,
    .cmdValid, .cmdReady, .cmdData, .txValid, .txReady, .txData,
    .rxValid, .rxReady, .rxData, .syncValid, .syncId);

endmodule

// File: tb/spi_offload_regs_tb.sv
module spi_offload_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irq, engineReset;
  logic        cmdValid, cmdReady = 1'b0;
  logic [15:0] cmdData;
  logic        txValid, txReady = 1'b0;
  logic [31:0] txData;
  logic        rxValid = 1'b0, rxReady;
  logic [31:0] rxData = '0;
  logic        syncValid = 1'b0;
  logic [7:0]  syncId = '0;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_offload_regs dut_i (.*);

  typedef struct packed {
    logic        isRead;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h40, 32'h0,    8'd2},   // R2 release
    '{1'b1, 8'h40, 32'h0,    8'd2},
    '{1'b0, 8'hE0, 32'hF1111, 8'd3},  // R3 upper bits discarded
    '{1'b0, 8'hE0, 32'h2222, 8'd3},
    '{1'b0, 8'hE0, 32'h3333, 8'd3},
    '{1'b1, 8'hD0, 32'd5,    8'd3},
    '{1'b1, 8'h84, 32'h2,    8'd7},   // R7 only tx almost empty
    '{1'b0, 8'h80, 32'hF,    8'd10},
    '{1'b1, 8'h80, 32'hF,    8'd10},
    '{1'b1, 8'h88, 32'h2,    8'd10},  // R10 source
    '{1'b0, 8'hE4, 32'hA,    8'd4},
    '{1'b0, 8'hE4, 32'hB,    8'd4},
    '{1'b0, 8'hE4, 32'hC,    8'd4},
    '{1'b1, 8'hD4, 32'd5,    8'd4},
    '{1'b1, 8'h84, 32'h0,    8'd7},
    '{1'b1, 8'h88, 32'h0,    8'd10},
    '{1'b1, 8'hC0, 32'h0,    8'd8},
    '{1'b1, 8'h10, 32'h0,    8'd11},  // R11 unmapped
    '{1'b1, 8'hE8, 32'h0,    8'd6},   // R6 pop empty
    '{1'b1, 8'hEC, 32'h0,    8'd6},
    '{1'b1, 8'hD8, 32'h0,    8'd5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic takeCmd(input logic [15:0] exp);
    @(negedge clk);
    chk("R3 cmdValid", 32'(cmdValid), 32'd1);
    chk("R3 cmdData", 32'(cmdData), 32'(exp));
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
  endtask

  task automatic takeTx(input logic [31:0] exp);
    @(negedge clk);
    chk("R4 txValid", 32'(txValid), 32'd1);
    chk("R4 txData", txData, exp);
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic pushRx(input logic [31:0] d);
    @(negedge clk);
    rxValid = 1'b1; rxData = d;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finishRun();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 engineReset", 32'(engineReset), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    busRead(8'h40, r); chk("R1 reset reg", r, 32'd1);
    busRead(8'h80, r); chk("R1 enable", r, 32'd0);
    busRead(8'hC0, r); chk("R1 sync id", r, 32'd0);
    busRead(8'hD0, r); chk("R1 cmd room", r, 32'd8);
    busRead(8'hD4, r); chk("R1 tx room", r, 32'd8);
    busRead(8'hD8, r); chk("R1 rx level", r, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRead) begin
        busRead(VECS[i].addr, r);
        checks++;
        if (r !== VECS[i].data) begin
          fails++;
          $display("FAIL R%0d vector %0d: actual 0x%0h expected 0x%0h",
                   VECS[i].req, i, r, VECS[i].data);
        end
      end else begin
        busWrite(VECS[i].addr, VECS[i].data);
      end
    end
    @(negedge clk);
    chk("R10 irq idle", 32'(irq), 32'd0);

    // R3 command order and low 16 bits
    takeCmd(16'h1111); takeCmd(16'h2222); takeCmd(16'h3333);
    @(negedge clk);
    chk("R3 cmd drained", 32'(cmdValid), 32'd0);
    busRead(8'h84, r); chk("R7 cmd almost empty", r, 32'h1);
    @(negedge clk);
    chk("R10 irq on cmd ae", 32'(irq), 32'd1);

    // R4 outgoing order
    takeTx(32'hA); takeTx(32'hB); takeTx(32'hC);

    // R5 incoming path
    for (int i = 0; i < 6; i++) pushRx(32'h100 + 32'(i));
    busRead(8'hD8, r); chk("R5 rx level", r, 32'd6);
    busRead(8'h84, r); chk("R7 rx almost full", r, 32'h7);
    busRead(8'hEC, r); chk("R5 peek", r, 32'h100);
    busRead(8'hD8, r); chk("R5 peek keeps level", r, 32'd6);
    busRead(8'hE8, r); chk("R5 pop 0", r, 32'h100);
    busRead(8'h84, r); chk("R7 rx below af", r, 32'h3);
    for (int i = 1; i < 6; i++) begin
      busRead(8'hE8, r); chk("R5 pop order", r, 32'h100 + 32'(i));
    end

    // R6 command queue overfill
    for (int i = 0; i < 10; i++) busWrite(8'hE0, 32'h4000 + 32'(i));
    busRead(8'hD0, r); chk("R6 cmd room full", r, 32'd0);
    for (int i = 0; i < 8; i++) takeCmd(16'h4000 + 16'(i));
    @(negedge clk);
    chk("R6 extra cmds dropped", 32'(cmdValid), 32'd0);

    // R6 incoming queue overfill
    for (int i = 0; i < 8; i++) pushRx(32'h200 + 32'(i));
    @(negedge clk);
    chk("R6 rxReady low when full", 32'(rxReady), 32'd0);
    pushRx(32'hDEAD);
    busRead(8'hD8, r); chk("R6 rx level capped", r, 32'd8);
    for (int i = 0; i < 8; i++) begin
      busRead(8'hE8, r); chk("R6 rx content intact", r, 32'h200 + 32'(i));
    end
    busRead(8'hE8, r); chk("R6 pop empty zero", r, 32'd0);
    busRead(8'hD8, r); chk("R6 level stays zero", r, 32'd0);

    // R8 sync latch, R9 clear, R10 masking
    busWrite(8'h80, 32'h8);
    @(negedge clk);
    syncValid = 1'b1; syncId = 8'h5A;
    @(negedge clk);
    syncValid = 1'b0;
    chk("R10 irq on sync", 32'(irq), 32'd1);
    busRead(8'hC0, r); chk("R8 sync id", r, 32'h5A);
    busRead(8'h84, r); chk("R8 sync pending", r, 32'hB);
    busRead(8'h88, r); chk("R10 source masked", r, 32'h8);
    busWrite(8'h84, 32'h7);
    busRead(8'h84, r); chk("R9 zero bit keeps sync", r, 32'hB);
    busWrite(8'h84, 32'h8);
    busRead(8'h84, r); chk("R9 clear sync", r, 32'h3);
    @(negedge clk);
    chk("R10 irq after clear", 32'(irq), 32'd0);
    @(negedge clk);
    syncValid = 1'b1; syncId = 8'h33;
    busWrEn = 1'b1; busAddr = 8'h84; busWrData = 32'h8;
    @(negedge clk);
    syncValid = 1'b0; busWrEn = 1'b0;
    busRead(8'h84, r); chk("R9 set wins over clear", r, 32'hB);
    busRead(8'hC0, r); chk("R8 second id", r, 32'h33);

    // R2 soft reset flushes and blocks
    busWrite(8'hE4, 32'h1); busWrite(8'hE4, 32'h2); busWrite(8'hE4, 32'h3);
    busWrite(8'h40, 32'h1);
    @(negedge clk);
    chk("R2 engineReset", 32'(engineReset), 32'd1);
    chk("R2 txValid flushed", 32'(txValid), 32'd0);
    chk("R2 rxReady low", 32'(rxReady), 32'd0);
    busRead(8'hD4, r); chk("R2 tx room flushed", r, 32'd8);
    busWrite(8'hE0, 32'h7777);
    busRead(8'hD0, r); chk("R2 push dropped in reset", r, 32'd8);
    busWrite(8'h40, 32'h0);
    @(negedge clk);
    chk("R2 released", 32'(engineReset), 32'd0);
    chk("R2 rxReady back", 32'(rxReady), 32'd1);

    finishRun();
  end

endmodule